// File: doc/BRIEF.md
# Two-Wire Serial Programming Controller

This block is the device-side controller for writing and verifying program memory in circuit over two signal pins. When the programming-voltage pin rises to its high level while both the clock pin and the data pin are held low, the block enters program/verify mode and resets its address counter to zero. While in this mode the clock pin acts as the programming clock and the data pin as a bidirectional serial data line.

Each transaction begins with a 6-bit command. A load command is followed by a 16-clock data frame carrying a 14-bit word into the device. A read command is followed by a 16-clock data frame that the device drives out. An increment command advances the address. The block drives an address, write data and single-cycle read and write strobes toward a program memory. It flags the four identification locations that lie just above the code space. While code protection is set, it returns zeros for any read outside those locations.

All three pins are asynchronous to `clk` and pass through a synchronizer of `SYNC_STAGES` flops. The programming clock must therefore stay in each level for several `clk` cycles.

Top module: `serial_prog_ctrl`

## Requirements
- R1: A rising edge on `vpp_high` while `pgm_clk` and `pgm_dat_in` are both low sets `prog_mode` to 1 and clears `mem_addr` to 0.
- R2: A rising edge on `vpp_high` while either `pgm_clk` or `pgm_dat_in` is high leaves `prog_mode` at 0.
- R3: Whenever `vpp_high` is low, the block leaves program/verify mode within a few cycles: `prog_mode` returns to 0 and `pgm_dat_oe` to 0, even in the middle of a frame.
- R4: Commands are 6 bits, sampled on falling edges of `pgm_clk`, least-significant bit first. The codes are load = 6'h02, read = 6'h04 and increment = 6'h06.
- R5: After a load command, 16 falling edges carry a frame made of one start bit, 14 data bits LSB first and one stop bit. After the stop bit the block writes the 14 data bits to `mem_addr` with one single-cycle `mem_wr` pulse.
- R6: A read command produces one single-cycle `mem_rd` pulse. `mem_rdata` is sampled one cycle after that pulse. The block then presents on `pgm_dat_out` a 16-bit frame: start bit 0, the 14 data bits LSB first, stop bit 0. Bit 0 is valid before the first falling edge of the data phase, and each falling edge advances the frame by one bit. `mem_rd` and `mem_wr` are never high together.
- R7: The increment command adds 1 to `mem_addr`, wrapping from the all-ones value to 0.
- R8: A command code other than the three listed is ignored: no strobe, no change of address and no drive of the data line.
- R9: `mem_id_sel` is 1 exactly when `mem_addr` lies in the range from `ID_BASE` to `ID_BASE+ID_COUNT-1`.
- R10: When `code_protect` is 1 at the time of the fetch and `mem_id_sel` is 0, the 14 data bits of the read frame are all zero. Identification locations read back normally whatever the state of `code_protect`.
- R11: `pgm_dat_oe` is 1 only during the data phase of a read command and 0 at all other times, including after reset.
- R12: `mem_addr` changes only by stepping up by 1 or by being cleared to 0 on mode entry. Load and read leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vpp_high | input | 1 | 1 when the programming-voltage pin is at its high level (asynchronous) |
| pgm_clk | input | 1 | Programming clock pin (asynchronous) |
| pgm_dat_in | input | 1 | Data pin input value (asynchronous) |
| pgm_dat_out | output | 1 | Data pin output value |
| pgm_dat_oe | output | 1 | Data pin output enable |
| code_protect | input | 1 | Code protection setting |
| prog_mode | output | 1 | 1 while in program/verify mode |
| mem_addr | output | ADDR_W | Program memory address counter |
| mem_wdata | output | 14 | Word to write |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_rd | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 14 | Read word, valid one cycle after `mem_rd` |
| mem_id_sel | output | 1 | Address lies in the identification range |

## Verification
The bench builds the block with `ADDR_W` = 6 and `ID_BASE` = 6'h10, keeping `ID_COUNT` = 4 and `SYNC_STAGES` = 2. With these values the identification range, the edge just past it and the wrap of the address counter can all be reached with a few dozen increment commands, which would take thousands with the default 14-bit space. The same values let protected and unprotected reads be compared at an ordinary address and at an identification address within one run, together with an exit in the middle of a read frame.

// File: rtl/sprog_pkg.sv
// Shared constants and types for the serial programming controller.
// Assumes: 6-bit commands and 16-clock data frames carrying 14-bit words.
package sprog_pkg;
    localparam int CMD_W   = 6;
    localparam int WORD_W  = 14;
    localparam int FRAME_W = WORD_W + 2;

    localparam logic [CMD_W-1:0] CMD_LOAD = 6'h02;
    localparam logic [CMD_W-1:0] CMD_READ = 6'h04;
    localparam logic [CMD_W-1:0] CMD_INC  = 6'h06;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMD,
        ST_LOAD,
        ST_FETCH,
        ST_SEND
    } sp_state_e;
endpackage

// File: rtl/sp_pin_sync.sv
// Multi-flop synchronizer for a group of asynchronous pins.
// Assumes: each pin is a slow level signal; bits are synchronized independently.
module sp_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pins in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Pass the value one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sp_addr_ctr.sv
// Program address counter with identification-range decode and read gating.
// Assumes: clear and step are never asserted together; ID range does not wrap.
module sp_addr_ctr #(
    parameter int                ADDR_W   = 14,
    parameter logic [ADDR_W-1:0] ID_BASE  = ADDR_W'('h2000),
    parameter int                ID_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              code_protect,
    output logic [ADDR_W-1:0] addr,
    output logic              id_sel,
    output logic              read_blocked
);
    localparam logic [ADDR_W-1:0] ID_SPAN = ADDR_W'(ID_COUNT);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;

    // Clear on mode entry, step up on the increment command.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr_q <= '0;
        else if (clear) addr_q <= '0;
        else if (step)  addr_q <= addr_q + ONE;
    end

    assign addr         = addr_q;
    assign id_sel       = (addr_q - ID_BASE) < ID_SPAN;
    assign read_blocked = code_protect & ~id_sel;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> (addr_q == '0) || (addr_q == $past(addr_q) + ONE)); // R12
endmodule

// File: rtl/serial_prog_ctrl.sv
// Device-side two-wire serial programming controller.
// Detects entry to program/verify mode, decodes 6-bit commands and moves
// 14-bit words framed by start and stop bits to and from program memory.
// Assumes: pins are asynchronous and slow compared with clk; memory returns
// read data one cycle after mem_rd.
module serial_prog_ctrl
    import sprog_pkg::*;
#(
    parameter int                ADDR_W      = 14,
    parameter logic [ADDR_W-1:0] ID_BASE     = ADDR_W'('h2000),
    parameter int                ID_COUNT    = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vpp_high,
    input  logic               pgm_clk,
    input  logic               pgm_dat_in,
    output logic               pgm_dat_out,
    output logic               pgm_dat_oe,
    input  logic               code_protect,
    output logic               prog_mode,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    output logic               mem_wr,
    output logic               mem_rd,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               mem_id_sel
);
    localparam int                CNT_W      = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0]  LAST_CMD   = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0]  LAST_FRAME = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0]  LAST_DATA  = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0]  CNT_ONE    = CNT_W'(1);

    logic [2:0]         pins_s;
    logic               vpp_s, clk_s, dat_s;
    logic               vpp_d, clk_d;
    logic               vpp_rise, clk_fall;
    sp_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [CMD_W-2:0]   cmd_sr;
    logic [CMD_W-1:0]   cmd_full;
    logic [WORD_W-1:0]  rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic               rd_q;
    logic               prot_q;
    logic               entry_ok;
    logic               cmd_done;
    logic               addr_step;
    logic               read_blocked;

    sp_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({vpp_high, pgm_clk, pgm_dat_in}),
        .sync_out (pins_s)
    );

    assign vpp_s = pins_s[2];
    assign clk_s = pins_s[1];
    assign dat_s = pins_s[0];

    // Delayed copies of the synchronized pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpp_d <= 1'b0;
            clk_d <= 1'b0;
        end else begin
            vpp_d <= vpp_s;
            clk_d <= clk_s;
        end
    end

    assign vpp_rise  = vpp_s & ~vpp_d;
    assign clk_fall  = clk_d & ~clk_s;
    assign entry_ok  = (state == ST_OFF) && vpp_rise && !clk_s && !dat_s;
    assign cmd_full  = {dat_s, cmd_sr};
    assign cmd_done  = (state == ST_CMD) && vpp_s && clk_fall && (cnt == LAST_CMD);
    assign addr_step = cmd_done && (cmd_full == CMD_INC);

    sp_addr_ctr #(
        .ADDR_W   (ADDR_W),
        .ID_BASE  (ID_BASE),
        .ID_COUNT (ID_COUNT)
    ) i_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (entry_ok),
        .step         (addr_step),
        .code_protect (code_protect),
        .addr         (mem_addr),
        .id_sel       (mem_id_sel),
        .read_blocked (read_blocked)
    );

    // Mode, command and frame sequencing with memory strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_OFF;
            cnt       <= '0;
            cmd_sr    <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            mem_wdata <= '0;
            mem_wr    <= 1'b0;
            mem_rd    <= 1'b0;
            rd_q      <= 1'b0;
            prot_q    <= 1'b0;
        end else begin
            mem_wr <= 1'b0;
            mem_rd <= 1'b0;
            rd_q   <= mem_rd;
            if (!vpp_s) begin
                state <= ST_OFF;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_OFF: begin
                        if (entry_ok) begin
                            state <= ST_CMD;
                            cnt   <= '0;
                        end
                    end
                    ST_CMD: begin
                        if (clk_fall) begin
                            cmd_sr <= cmd_full[CMD_W-1:1];
                            if (cnt == LAST_CMD) begin
                                cnt <= '0;
                                if (cmd_full == CMD_LOAD) begin
                                    state <= ST_LOAD;
                                end else if (cmd_full == CMD_READ) begin
                                    state  <= ST_FETCH;
                                    mem_rd <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + CNT_ONE;
                            end
                        end
                    end
                    ST_LOAD: begin
                        if (clk_fall) begin
                            if (cnt != '0 && cnt <= LAST_DATA)
                                rx_sr <= {dat_s, rx_sr[WORD_W-1:1]};
                            if (cnt == LAST_FRAME) begin
                                mem_wdata <= rx_sr;
                                mem_wr    <= 1'b1;
                                state     <= ST_CMD;
                                cnt       <= '0;
                            end else begin
                                cnt <= cnt + CNT_ONE;
                            end
                        end
                    end
                    ST_FETCH: begin
                        if (rd_q) begin
                            tx_sr  <= {1'b0, (read_blocked ? '0 : mem_rdata), 1'b0};
                            prot_q <= read_blocked;
                            state  <= ST_SEND;
                            cnt    <= '0;
                        end
                    end
                    ST_SEND: begin
                        if (clk_fall) begin
                            tx_sr <= {1'b0, tx_sr[FRAME_W-1:1]};
                            if (cnt == LAST_FRAME) begin
                                state <= ST_CMD;
                                cnt   <= '0;
                            end else begin
                                cnt <= cnt + CNT_ONE;
                            end
                        end
                    end
                    default: state <= ST_OFF;
                endcase
            end
        end
    end

    assign prog_mode   = (state != ST_OFF);
    assign pgm_dat_oe  = (state == ST_SEND);
    assign pgm_dat_out = pgm_dat_oe & tx_sr[0];

    AST_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> (mem_addr == '0)); // R1
    AST_EXIT_LOW_VPP: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_s |=> !prog_mode && !pgm_dat_oe); // R3
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R6
    AST_PROT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_dat_oe && prot_q) |-> !pgm_dat_out); // R10
    AST_OE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_dat_oe |-> prog_mode && !mem_wr); // R11
endmodule

// File: tb/test_serial_prog_ctrl.sv
`timescale 1ns/1ps
module test_serial_prog_ctrl;
    localparam int AW   = 6;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vpp_high = 1'b0;
    logic          pgm_clk = 1'b0;
    logic          pgm_dat_in = 1'b0;
    logic          pgm_dat_out, pgm_dat_oe;
    logic          code_protect = 1'b0;
    logic          prog_mode;
    logic [AW-1:0] mem_addr;
    logic [13:0]   mem_wdata;
    logic          mem_wr, mem_rd;
    logic [13:0]   mem_rdata = '0;
    logic          mem_id_sel;

    int n_cmp = 0;
    int n_mis = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] a;
        logic [13:0]   d;
    } wr_item_t;
    wr_item_t exp_q[$];

    logic [13:0] mem_model [64];

    always #2 clk = ~clk;

    serial_prog_ctrl #(
        .ADDR_W      (AW),
        .ID_BASE     (6'h10),
        .ID_COUNT    (4),
        .SYNC_STAGES (2)
    ) i_serial_prog_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .vpp_high     (vpp_high),
        .pgm_clk      (pgm_clk),
        .pgm_dat_in   (pgm_dat_in),
        .pgm_dat_out  (pgm_dat_out),
        .pgm_dat_oe   (pgm_dat_oe),
        .code_protect (code_protect),
        .prog_mode    (prog_mode),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wr       (mem_wr),
        .mem_rd       (mem_rd),
        .mem_rdata    (mem_rdata),
        .mem_id_sel   (mem_id_sel)
    );

    initial begin
        for (int i = 0; i < 64; i++) mem_model[i] = '0;
    end

    // Program memory model: registered read, write on strobe.
    always @(posedge clk) begin
        if (mem_wr) mem_model[mem_addr] <= mem_wdata;
        mem_rdata <= mem_model[mem_addr];
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every write strobe pops one expected item.
    always @(negedge clk) begin
        if (rst_n && mem_rd) rd_seen++;
        if (rst_n && mem_wr) begin
            wr_seen++;
            if (exp_q.size() == 0) begin
                check("R5 unexpected write", 32'(mem_addr), 32'hFFFF);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check("R5 write address", 32'(mem_addr), 32'(it.a));
                check("R5 write data", 32'(mem_wdata), 32'(it.d));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        pgm_dat_in = b;
        pgm_clk = 1'b1;
        tick(HALF);
        pgm_clk = 1'b0;
        tick(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) send_bit(c[i]);
        pgm_dat_in = 1'b0;
    endtask

    task automatic load_word(input logic [13:0] d);
        wr_item_t it;
        it.a = mem_addr;
        it.d = d;
        exp_q.push_back(it);
        send_cmd(6'h02);
        send_bit(1'b0);
        for (int i = 0; i < 14; i++) send_bit(d[i]);
        send_bit(1'b0);
        pgm_dat_in = 1'b0;
        tick(4);
    endtask

    task automatic read_word(output logic [13:0] w, output logic frame_ok, output logic oe_ok);
        logic [15:0] fr;
        send_cmd(6'h04);
        oe_ok = 1'b1;
        for (int k = 0; k < 16; k++) begin
            pgm_clk = 1'b1;
            tick(HALF);
            fr[k] = pgm_dat_out;
            if (pgm_dat_oe !== 1'b1) oe_ok = 1'b0;
            pgm_clk = 1'b0;
            tick(HALF);
        end
        w = fr[14:1];
        frame_ok = (fr[0] == 1'b0) && (fr[15] == 1'b0);
    endtask

    task automatic enter_mode();
        pgm_clk = 1'b0;
        pgm_dat_in = 1'b0;
        vpp_high = 1'b1;
        tick(8);
    endtask

    task automatic leave_mode();
        vpp_high = 1'b0;
        tick(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_mis++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    initial begin
        logic [13:0] w;
        logic fok, ook;
        int wr0, rd0;
        logic [AW-1:0] a0;

        tick(5);
        rst_n = 1'b1;
        tick(2);
        check("R11 reset oe", 32'(pgm_dat_oe), 0);
        check("R3 reset prog_mode", 32'(prog_mode), 0);
        check("R5 reset wr", 32'(mem_wr), 0);

        // R2: entry refused with clock pin high, then with data pin high
        pgm_clk = 1'b1;
        vpp_high = 1'b1;
        tick(8);
        check("R2 clock high at rise", 32'(prog_mode), 0);
        leave_mode();
        pgm_clk = 1'b0;
        pgm_dat_in = 1'b1;
        vpp_high = 1'b1;
        tick(8);
        check("R2 data high at rise", 32'(prog_mode), 0);
        leave_mode();

        // R1: proper entry
        enter_mode();
        check("R1 entry prog_mode", 32'(prog_mode), 1);
        check("R1 entry address", 32'(mem_addr), 0);

        // R5 / R6 / R4: load and read back at address 0
        load_word(14'h1ABC);
        check("R12 address after load", 32'(mem_addr), 0);
        read_word(w, fok, ook);
        check("R6 R4 read data", 32'(w), 32'h1ABC);
        check("R6 start/stop bits", 32'(fok), 1);
        check("R11 oe during data phase", 32'(ook), 1);
        tick(HALF);
        check("R11 oe after frame", 32'(pgm_dat_oe), 0);
        check("R12 address after read", 32'(mem_addr), 0);

        // R7: increment and a second word
        send_cmd(6'h06);
        tick(4);
        check("R7 increment", 32'(mem_addr), 1);
        load_word(14'h0555);
        read_word(w, fok, ook);
        check("R6 read second word", 32'(w), 32'h0555);

        // R8: unknown codes ignored (6'h10 is the load code sent MSB first)
        wr0 = wr_seen;
        rd0 = rd_seen;
        a0  = mem_addr;
        send_cmd(6'h3F);
        send_cmd(6'h10);
        send_cmd(6'h00);
        tick(4);
        check("R8 no write", 32'(wr_seen), 32'(wr0));
        check("R8 no read", 32'(rd_seen), 32'(rd0));
        check("R8 address kept", 32'(mem_addr), 32'(a0));
        check("R8 line not driven", 32'(pgm_dat_oe), 0);

        // R3 / R1: leave and re-enter, address back to zero
        leave_mode();
        check("R3 exit prog_mode", 32'(prog_mode), 0);
        enter_mode();
        check("R1 re-entry address", 32'(mem_addr), 0);

        // R10: protected read of ordinary location
        code_protect = 1'b1;
        read_word(w, fok, ook);
        check("R10 protected read zero", 32'(w), 0);
        code_protect = 1'b0;

        // R9 / R10: walk to the identification range
        for (int i = 0; i < 16; i++) send_cmd(6'h06);
        tick(4);
        check("R9 id base address", 32'(mem_addr), 32'h10);
        check("R9 id select at base", 32'(mem_id_sel), 1);
        load_word(14'h2AAA);
        code_protect = 1'b1;
        read_word(w, fok, ook);
        check("R10 id readable when protected", 32'(w), 32'h2AAA);
        code_protect = 1'b0;
        for (int i = 0; i < 3; i++) send_cmd(6'h06);
        tick(4);
        check("R9 id select at last", 32'(mem_id_sel), 1);
        send_cmd(6'h06);
        tick(4);
        check("R9 id select past range", 32'(mem_id_sel), 0);

        // R7: wrap of the address counter
        for (int i = 20; i < 63; i++) send_cmd(6'h06);
        tick(4);
        check("R7 top address", 32'(mem_addr), 63);
        send_cmd(6'h06);
        tick(4);
        check("R7 wrap to zero", 32'(mem_addr), 0);
        read_word(w, fok, ook);
        check("R6 read after wrap", 32'(w), 32'h1ABC);

        // R3: exit in the middle of a read frame
        send_cmd(6'h04);
        for (int k = 0; k < 3; k++) begin
            pgm_clk = 1'b1;
            tick(HALF);
            pgm_clk = 1'b0;
            tick(HALF);
        end
        check("R11 oe mid frame", 32'(pgm_dat_oe), 1);
        leave_mode();
        check("R3 oe released on exit", 32'(pgm_dat_oe), 0);
        check("R3 mode left on exit", 32'(prog_mode), 0);

        check("R5 all writes seen", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule